// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits on the device side of a NOR-style parallel flash bus and watches the synchronous write cycles the host issues. Each write carries an address and a 16-bit data word. The block matches these writes against multi-write unlock and command sequences and uses them to switch between operating modes. The modes are array read, identifier read, fast-program (bypass), program busy, erase busy and erase suspended. When a sequence completes, the block emits a single-cycle operation pulse together with the captured address and data.

In identifier mode, a read addressed to the selected bank returns one registered identifier or status word. All other reads are left to the storage array. Program and erase busy time is modelled by two down-counters. Either counter can be cut short by an external completion input. The erase counter stays frozen while an erase is suspended.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode_o is read (0), busy_o is low and no operation pulse is active. Mode codes: read 0, identifier 1, bypass 2, program busy 3, erase busy 4, erase suspended 5.
- R2: The writes AA@555, 55@2AA, 90@555 enter identifier mode for the bank in address bits [ADDR_W-1:ADDR_W-2]. A read one cycle later in that bank returns the following, with id_sel_o high: 0001 at offset 00, 227E at offset 01, 2202 at offset 0E and 2200 at offset 0F. Offsets are address bits [7:0], and commands are matched on address bits [11:0].
- R3: In identifier mode, offset 02 returns 0001 when sect_locked_i is high and 0000 when it is low. Offset 03 returns 0043 when HANDSHAKE=1 and 0042 when HANDSHAKE=0. A read in any other bank leaves id_sel_o low.
- R4: A write of F0 leaves identifier mode. The block goes back to read, or to erase suspended if identifier mode was entered from there. In read or erase suspended mode, F0 changes nothing.
- R5: The writes AA@555, 55@2AA, A0@555 followed by a fourth write pulse op_prog_o with that write's full address and data, and the block enters program busy. It returns to the mode it came from after PROG_CYC cycles, or on busy_done_i.
- R6: The writes AA@555, 55@2AA, 20@555 enter bypass mode. In bypass mode, A0 at any address followed by one write programs, and the block then returns to bypass. A write of 90 in the bypass bank followed by 00 returns the block to read.
- R7: The writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 pulse op_chip_erase_o. The same five writes followed by 30 at any address pulse op_sect_erase_o with that address. Both enter erase busy, which ends after ERASE_CYC running cycles or on busy_done_i. At most one operation pulse is active at a time.
- R8: B0 in the erasing bank pulses op_suspend_o and enters erase suspended, but only during a sector erase. Outside that case B0 has no effect.
- R9: In erase suspended mode, a write of 30 in the erasing bank pulses op_resume_o and returns to erase busy. The remaining erase count continues from where it stopped.
- R10: Data bits [15:8] are ignored when command codes are matched.
- R11: A write that does not fit the next step of a sequence abandons that sequence. No pulse is emitted and the mode stays as it was before the sequence started.
- R12: While program or erase busy, every write except a valid suspend is ignored. The next write after busy ends starts a fresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write cycle strobe |
| rd_en_i | input | 1 | Read cycle strobe |
| addr_i | input | ADDR_W | Cycle address |
| wdata_i | input | 16 | Write data |
| sect_locked_i | input | 1 | Lock status of the addressed sector |
| busy_done_i | input | 1 | External completion of program or erase |
| mode_o | output | 3 | Current mode code |
| busy_o | output | 1 | Program or erase busy |
| rdata_o | output | 16 | Identifier or status word |
| id_sel_o | output | 1 | rdata_o holds an identifier word for the previous read |
| op_prog_o | output | 1 | Program request pulse |
| op_chip_erase_o | output | 1 | Chip erase request pulse |
| op_sect_erase_o | output | 1 | Sector erase request pulse |
| op_suspend_o | output | 1 | Erase suspend pulse |
| op_resume_o | output | 1 | Erase resume pulse |
| op_addr_o | output | ADDR_W | Address captured with the last operation |
| op_data_o | output | 16 | Data captured with the last program |

## Verification
The bench builds the block with PROG_CYC=6, ERASE_CYC=40 and HANDSHAKE=1. These short busy windows let counter expiry be observed on the exact cycle for a program. They also let a suspended sector erase be resumed and then run to completion within a few dozen cycles. ADDR_W stays at 22, so bank selection through bits 21:20 and the wrong-bank cases for suspend, resume, bypass exit and identifier reads can all be exercised directly.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    MODE_READ    = 3'd0,
    MODE_AUTOSEL = 3'd1,
    MODE_BYPASS  = 3'd2,
    MODE_PROG    = 3'd3,
    MODE_ERASE   = 3'd4,
    MODE_SUSP    = 3'd5
  } mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PG, ST_E3, ST_E4, ST_E5, ST_BP_PG, ST_BP_EXIT
  } step_e;

  localparam logic [7:0]  CMD_KEY1     = 8'hAA;
  localparam logic [7:0]  CMD_KEY2     = 8'h55;
  localparam logic [7:0]  CMD_IDENT    = 8'h90;
  localparam logic [7:0]  CMD_PROG     = 8'hA0;
  localparam logic [7:0]  CMD_BYPASS   = 8'h20;
  localparam logic [7:0]  CMD_ERSETUP  = 8'h80;
  localparam logic [7:0]  CMD_CHIP     = 8'h10;
  localparam logic [7:0]  CMD_SECT     = 8'h30;
  localparam logic [7:0]  CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0]  CMD_EXIT     = 8'hF0;
  localparam logic [7:0]  CMD_BP_CLR   = 8'h00;
  localparam logic [11:0] ADR_KEY1     = 12'h555;
  localparam logic [11:0] ADR_KEY2     = 12'h2AA;
endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int unsigned LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic ext_done_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (ext_done_i || cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (start_i)                 cnt_q <= CW'(LEN);
    else if (done_o)                  cnt_q <= '0;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom #(
  parameter logic [15:0] MFR_ID    = 16'h0001,
  parameter logic [15:0] DEV_ID1   = 16'h227E,
  parameter logic [15:0] DEV_ID2   = 16'h2202,
  parameter logic [15:0] DEV_ID3   = 16'h2200,
  parameter bit          HANDSHAKE = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_en_i,
  input  logic        hit_i,
  input  logic [7:0]  ofs_i,
  input  logic        sect_locked_i,
  output logic [15:0] rdata_o,
  output logic        id_sel_o
);
  logic [15:0] word;

  always_comb begin
    unique case (ofs_i)
      8'h00:   word = MFR_ID;
      8'h01:   word = DEV_ID1;
      8'h02:   word = {15'd0, sect_locked_i};
      8'h03:   word = HANDSHAKE ? 16'h0043 : 16'h0042;
      8'h0E:   word = DEV_ID2;
      8'h0F:   word = DEV_ID3;
      default: word = 16'h0000;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      id_sel_o <= 1'b0;
    end else begin
      id_sel_o <= rd_en_i && hit_i;
      if (rd_en_i && hit_i) rdata_o <= word;
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              prog_done_i,
  input  logic              erase_done_i,
  output mode_e             mode_o,
  output logic [1:0]        as_bank_o,
  output logic              op_prog_o,
  output logic              op_chip_o,
  output logic              op_sect_o,
  output logic              op_susp_o,
  output logic              op_resume_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [15:0]       op_data_o
);
  mode_e mode_q, mode_d, ret_q, ret_d;
  step_e step_q, step_d;
  logic [1:0] as_bank_q, as_bank_d, er_bank_q, er_bank_d;
  logic er_sect_q, er_sect_d;
  logic prog_d, chip_d, sect_d, susp_d, resume_d;
  logic [ADDR_W-1:0] op_addr_d;
  logic [15:0] op_data_d;

  logic [7:0]  cd;
  logic [1:0]  bk;
  logic        at_a, at_b;

  assign cd   = wdata_i[7:0];
  assign bk   = addr_i[ADDR_W-1 -: 2];
  assign at_a = addr_i[11:0] == ADR_KEY1;
  assign at_b = addr_i[11:0] == ADR_KEY2;

  always_comb begin
    mode_d    = mode_q;
    step_d    = step_q;
    ret_d     = ret_q;
    as_bank_d = as_bank_q;
    er_bank_d = er_bank_q;
    er_sect_d = er_sect_q;
    op_addr_d = op_addr_o;
    op_data_d = op_data_o;
    prog_d = 1'b0; chip_d = 1'b0; sect_d = 1'b0; susp_d = 1'b0; resume_d = 1'b0;

    if (mode_q == MODE_PROG && prog_done_i) begin
      mode_d = ret_q;
      step_d = ST_IDLE;
    end else if (mode_q == MODE_ERASE && erase_done_i) begin
      mode_d = MODE_READ;
      step_d = ST_IDLE;
    end else if (wr_en_i) begin
      case (mode_q)
        MODE_PROG: ;
        MODE_ERASE: begin
          if (cd == CMD_SUSPEND && er_sect_q && bk == er_bank_q) begin
            mode_d    = MODE_SUSP;
            susp_d    = 1'b1;
            op_addr_d = addr_i;
          end
        end
        MODE_AUTOSEL: if (cd == CMD_EXIT) mode_d = ret_q;
        MODE_BYPASS: begin
          step_d = ST_IDLE;
          case (step_q)
            ST_IDLE: begin
              if (cd == CMD_PROG) step_d = ST_BP_PG;
              else if (cd == CMD_IDENT && bk == as_bank_q) step_d = ST_BP_EXIT;
            end
            ST_BP_PG: begin
              prog_d    = 1'b1;
              op_addr_d = addr_i;
              op_data_d = wdata_i;
              ret_d     = MODE_BYPASS;
              mode_d    = MODE_PROG;
            end
            ST_BP_EXIT: if (cd == CMD_BP_CLR) mode_d = MODE_READ;
            default: ;
          endcase
        end
        default: begin // read or erase-suspended: full unlock sequences
          step_d = ST_IDLE;
          case (step_q)
            ST_IDLE: begin
              if (cd == CMD_KEY1 && at_a) step_d = ST_U1;
              else if (mode_q == MODE_SUSP && cd == CMD_SECT && bk == er_bank_q) begin
                mode_d    = MODE_ERASE;
                resume_d  = 1'b1;
                op_addr_d = addr_i;
              end
            end
            ST_U1: if (cd == CMD_KEY2 && at_b) step_d = ST_U2;
            ST_U2: begin
              if (at_a) begin
                if (cd == CMD_IDENT) begin
                  mode_d    = MODE_AUTOSEL;
                  ret_d     = mode_q;
                  as_bank_d = bk;
                end else if (cd == CMD_PROG) begin
                  step_d = ST_PG;
                end else if (cd == CMD_BYPASS && mode_q == MODE_READ) begin
                  mode_d    = MODE_BYPASS;
                  as_bank_d = bk;
                end else if (cd == CMD_ERSETUP && mode_q == MODE_READ) begin
                  step_d = ST_E3;
                end
              end
            end
            ST_PG: begin
              prog_d    = 1'b1;
              op_addr_d = addr_i;
              op_data_d = wdata_i;
              ret_d     = mode_q;
              mode_d    = MODE_PROG;
            end
            ST_E3: if (cd == CMD_KEY1 && at_a) step_d = ST_E4;
            ST_E4: if (cd == CMD_KEY2 && at_b) step_d = ST_E5;
            ST_E5: begin
              if (cd == CMD_CHIP && at_a) begin
                chip_d    = 1'b1;
                op_addr_d = addr_i;
                er_sect_d = 1'b0;
                mode_d    = MODE_ERASE;
              end else if (cd == CMD_SECT) begin
                sect_d    = 1'b1;
                op_addr_d = addr_i;
                er_sect_d = 1'b1;
                er_bank_d = bk;
                mode_d    = MODE_ERASE;
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_READ;
      ret_q       <= MODE_READ;
      step_q      <= ST_IDLE;
      as_bank_q   <= '0;
      er_bank_q   <= '0;
      er_sect_q   <= 1'b0;
      op_prog_o   <= 1'b0;
      op_chip_o   <= 1'b0;
      op_sect_o   <= 1'b0;
      op_susp_o   <= 1'b0;
      op_resume_o <= 1'b0;
      op_addr_o   <= '0;
      op_data_o   <= '0;
    end else begin
      mode_q      <= mode_d;
      ret_q       <= ret_d;
      step_q      <= step_d;
      as_bank_q   <= as_bank_d;
      er_bank_q   <= er_bank_d;
      er_sect_q   <= er_sect_d;
      op_prog_o   <= prog_d;
      op_chip_o   <= chip_d;
      op_sect_o   <= sect_d;
      op_susp_o   <= susp_d;
      op_resume_o <= resume_d;
      op_addr_o   <= op_addr_d;
      op_data_o   <= op_data_d;
    end
  end

  assign mode_o    = mode_q;
  assign as_bank_o = as_bank_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned PROG_CYC  = 200,
  parameter int unsigned ERASE_CYC = 5000,
  parameter bit          HANDSHAKE = 1'b1,
  parameter logic [15:0] MFR_ID    = 16'h0001,
  parameter logic [15:0] DEV_ID1   = 16'h227E,
  parameter logic [15:0] DEV_ID2   = 16'h2202,
  parameter logic [15:0] DEV_ID3   = 16'h2200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              sect_locked_i,
  input  logic              busy_done_i,
  output logic [2:0]        mode_o,
  output logic              busy_o,
  output logic [15:0]       rdata_o,
  output logic              id_sel_o,
  output logic              op_prog_o,
  output logic              op_chip_erase_o,
  output logic              op_sect_erase_o,
  output logic              op_suspend_o,
  output logic              op_resume_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [15:0]       op_data_o
);
  mode_e      mode;
  logic [1:0] as_bank;
  logic       prog_done, erase_done, id_hit;

  flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .prog_done_i  (prog_done),
    .erase_done_i (erase_done),
    .mode_o       (mode),
    .as_bank_o    (as_bank),
    .op_prog_o    (op_prog_o),
    .op_chip_o    (op_chip_erase_o),
    .op_sect_o    (op_sect_erase_o),
    .op_susp_o    (op_suspend_o),
    .op_resume_o  (op_resume_o),
    .op_addr_o    (op_addr_o),
    .op_data_o    (op_data_o)
  );

  flash_busy_timer #(.LEN(PROG_CYC)) u_prog_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (op_prog_o),
    .run_i      (mode == MODE_PROG),
    .ext_done_i (busy_done_i),
    .done_o     (prog_done)
  );

  // frozen while suspended: run only in erase-busy mode
  flash_busy_timer #(.LEN(ERASE_CYC)) u_erase_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (op_chip_erase_o || op_sect_erase_o),
    .run_i      (mode == MODE_ERASE),
    .ext_done_i (busy_done_i),
    .done_o     (erase_done)
  );

  assign id_hit = mode == MODE_AUTOSEL && addr_i[ADDR_W-1 -: 2] == as_bank;

  flash_id_rom #(
    .MFR_ID(MFR_ID), .DEV_ID1(DEV_ID1), .DEV_ID2(DEV_ID2), .DEV_ID3(DEV_ID3),
    .HANDSHAKE(HANDSHAKE)
  ) u_id (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_en_i       (rd_en_i),
    .hit_i         (id_hit),
    .ofs_i         (addr_i[7:0]),
    .sect_locked_i (sect_locked_i),
    .rdata_o       (rdata_o),
    .id_sel_o      (id_sel_o)
  );

  assign mode_o = mode;
  assign busy_o = mode == MODE_PROG || mode == MODE_ERASE;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_en_i,
  input logic [2:0] mode_o,
  input logic       busy_o,
  input logic       id_sel_o,
  input logic       op_prog_o,
  input logic       op_chip_erase_o,
  input logic       op_sect_erase_o,
  input logic       op_suspend_o,
  input logic       op_resume_o
);
  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (mode_o == MODE_READ && !busy_o));

  assert_id_only_in_ident_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_sel_o |-> ($past(mode_o) == MODE_AUTOSEL && $past(rd_en_i)));

  assert_prog_enters_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_prog_o |-> (mode_o == MODE_PROG && busy_o));

  assert_single_op_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({op_prog_o, op_chip_erase_o, op_sect_erase_o, op_suspend_o, op_resume_o}));

  assert_suspend_from_erase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_suspend_o |-> ($past(mode_o) == MODE_ERASE && mode_o == MODE_SUSP));

  assert_resume_from_susp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_resume_o |-> ($past(mode_o) == MODE_SUSP && mode_o == MODE_ERASE));

  assert_busy_blocks_ops_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !(op_prog_o || op_chip_erase_o || op_sect_erase_o || op_resume_o));
endmodule

bind flash_cmd_decoder flash_cmd_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rd_en_i         (rd_en_i),
  .mode_o          (mode_o),
  .busy_o          (busy_o),
  .id_sel_o        (id_sel_o),
  .op_prog_o       (op_prog_o),
  .op_chip_erase_o (op_chip_erase_o),
  .op_sect_erase_o (op_sect_erase_o),
  .op_suspend_o    (op_suspend_o),
  .op_resume_o     (op_resume_o)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  localparam int unsigned AW = 22;
  localparam int unsigned PC = 6;
  localparam int unsigned EC = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, locked = 1'b0, bdone = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [2:0] mode;
  logic busy, id_sel, o_prog, o_chip, o_sect, o_susp, o_res;
  logic [15:0] rdata, o_data;
  logic [AW-1:0] o_addr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .PROG_CYC(PC), .ERASE_CYC(EC), .HANDSHAKE(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .sect_locked_i(locked), .busy_done_i(bdone), .mode_o(mode),
    .busy_o(busy), .rdata_o(rdata), .id_sel_o(id_sel), .op_prog_o(o_prog),
    .op_chip_erase_o(o_chip), .op_sect_erase_o(o_sect), .op_suspend_o(o_susp),
    .op_resume_o(o_res), .op_addr_o(o_addr), .op_data_o(o_data));

  function automatic logic [4:0] ops();
    return {o_prog, o_chip, o_sect, o_susp, o_res};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); bdone = 1'b1;
    @(negedge clk); bdone = 1'b0;
  endtask

  task automatic unlock(input logic [AW-1:0] base);
    wr(base | 22'h555, 16'h00AA);
    wr(base | 22'h2AA, 16'h0055);
  endtask

  task automatic t_reset();
    check("R1", "mode", mode, 3'd0);
    check("R1", "busy", busy, 1'b0);
    check("R1", "ops", ops(), 5'b0);
  endtask

  task automatic t_ident();
    unlock(22'h100000); wr(22'h100555, 16'h0090);
    check("R2", "mode ident", mode, 3'd1);
    rd(22'h100000); check("R2", "ofs00", rdata, 16'h0001); check("R2", "sel", id_sel, 1'b1);
    rd(22'h100001); check("R2", "ofs01", rdata, 16'h227E);
    rd(22'h10000E); check("R2", "ofs0E", rdata, 16'h2202);
    rd(22'h10000F); check("R2", "ofs0F", rdata, 16'h2200);
    locked = 1'b1; rd(22'h13A002); check("R3", "locked", rdata, 16'h0001);
    locked = 1'b0; rd(22'h13A002); check("R3", "unlocked", rdata, 16'h0000);
    rd(22'h100003); check("R3", "handshake", rdata, 16'h0043);
    rd(22'h000001); check("R3", "other bank sel", id_sel, 1'b0);
    wr(22'h000000, 16'h00F0); check("R4", "exit ident", mode, 3'd0);
    wr(22'h000000, 16'h00F0); check("R4", "F0 in read", mode, 3'd0);
  endtask

  task automatic t_program();
    unlock(0); wr(22'h000555, 16'h00A0); wr(22'h012345, 16'hBEEF);
    check("R5", "prog pulse", ops(), 5'b10000);
    check("R5", "addr", o_addr, 22'h012345);
    check("R5", "data", o_data, 16'hBEEF);
    check("R5", "mode prog", mode, 3'd3);
    repeat (PC) @(negedge clk);
    check("R5", "still busy", busy, 1'b1);
    @(negedge clk);
    check("R5", "done read", mode, 3'd0);
  endtask

  task automatic t_upper();
    wr(22'h000555, 16'h12AA); wr(22'h0002AA, 16'hFF55); wr(22'h000555, 16'h34A0);
    wr(22'h000100, 16'h5A5A);
    check("R10", "prog with high bits", ops(), 5'b10000);
    pulse_done();
    check("R10", "ext done", mode, 3'd0);
  endtask

  task automatic t_abort();
    unlock(0); wr(22'h000555, 16'h0077);
    check("R11", "bad third", ops(), 5'b0);
    check("R11", "mode", mode, 3'd0);
    wr(22'h000555, 16'h00AA); wr(22'h000123, 16'h0055); wr(22'h000555, 16'h00A0);
    wr(22'h000200, 16'h1111);
    check("R11", "bad second addr", ops(), 5'b0);
    check("R11", "mode after", mode, 3'd0);
  endtask

  task automatic t_bypass();
    unlock(0); wr(22'h000555, 16'h0020);
    check("R6", "enter bypass", mode, 3'd2);
    wr(22'h0ABCDE, 16'h00A0); wr(22'h000777, 16'h1234);
    check("R6", "bypass prog", ops(), 5'b10000);
    check("R6", "bypass data", o_data, 16'h1234);
    repeat (PC + 1) @(negedge clk);
    check("R6", "back to bypass", mode, 3'd2);
    wr(22'h000000, 16'h0090); wr(22'h000000, 16'h0055);
    check("R11", "bypass bad exit", mode, 3'd2);
    wr(22'h100000, 16'h0090); wr(22'h100000, 16'h0000);
    check("R6", "exit wrong bank", mode, 3'd2);
    wr(22'h000000, 16'h0090); wr(22'h000000, 16'h0000);
    check("R6", "exit bypass", mode, 3'd0);
  endtask

  task automatic t_busy();
    unlock(0); wr(22'h000555, 16'h00A0); wr(22'h000010, 16'h0001);
    wr(22'h000555, 16'h00AA);
    check("R12", "busy ignores", mode, 3'd3);
    pulse_done();
    check("R12", "ext done", mode, 3'd0);
    wr(22'h0002AA, 16'h0055); wr(22'h000555, 16'h00A0); wr(22'h000020, 16'h0002);
    check("R12", "no stale seq", ops(), 5'b0);
  endtask

  task automatic erase_pre(input logic [AW-1:0] base);
    unlock(base); wr(base | 22'h555, 16'h0080); unlock(base);
  endtask

  task automatic t_chip();
    wr(22'h000000, 16'h00B0);
    check("R8", "B0 in read", ops(), 5'b0);
    erase_pre(0); wr(22'h000555, 16'h0010);
    check("R7", "chip pulse", ops(), 5'b01000);
    check("R7", "erase busy", mode, 3'd4);
    wr(22'h000000, 16'h00B0);
    check("R8", "no suspend chip", ops(), 5'b0);
    check("R8", "still erase", mode, 3'd4);
    pulse_done();
    check("R7", "chip done", mode, 3'd0);
  endtask

  task automatic t_sector();
    bit seen;
    erase_pre(0); wr(22'h203000, 16'h0030);
    check("R7", "sect pulse", ops(), 5'b00100);
    check("R7", "sect addr", o_addr, 22'h203000);
    wr(22'h000000, 16'h00B0);
    check("R8", "wrong bank B0", ops(), 5'b0);
    wr(22'h200000, 16'h00B0);
    check("R8", "suspend pulse", ops(), 5'b00010);
    check("R8", "suspended", mode, 3'd5);
    wr(22'h000000, 16'h0030);
    check("R9", "wrong bank resume", ops(), 5'b0);
    wr(22'h000000, 16'h00F0);
    check("R4", "F0 in suspend", mode, 3'd5);
    unlock(0); wr(22'h000555, 16'h0090);
    check("R4", "ident from susp", mode, 3'd1);
    wr(22'h000000, 16'h00F0);
    check("R4", "back to susp", mode, 3'd5);
    unlock(0); wr(22'h000555, 16'h00A0); wr(22'h000040, 16'h4444);
    check("R5", "prog in susp", ops(), 5'b10000);
    repeat (PC + 1) @(negedge clk);
    check("R5", "return susp", mode, 3'd5);
    wr(22'h2FF000, 16'h0030);
    check("R9", "resume pulse", ops(), 5'b00001);
    check("R9", "erase again", mode, 3'd4);
    seen = 1'b0;
    for (int i = 0; i < EC + 5; i++) begin
      @(negedge clk);
      if (mode == 3'd0) begin seen = 1'b1; break; end
    end
    check("R9", "erase finishes", seen, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_program();
    t_upper();
    t_abort();
    t_bypass();
    t_busy();
    t_chip();
    t_sector();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule